// File: doc/BRIEF.md
# Attribute-Ordered Store Issue Queue

This block buffers write transactions on their way to the system bus. Each write arrives with an address, a data word and four one-bit memory attributes: write-through, cache-inhibited, coherence-required and guarded. From these bits the block derives a cacheable flag, a write-through flag and a snoop-required flag, and it sends them out with each write. A write that asks for both write-through and cache-inhibited handling is not supported. The block consumes such a write, never stores it, and raises an error pulse.

Writes that are both cache-inhibited and guarded are ordered. They leave the queue strictly in the order they were accepted, whatever their address and whatever their coherence bit. All other writes are plain. They are not ordered among themselves and get precedence, so they can overtake ordered writes that are waiting. Both edges use a valid/ready handshake, and the queue holds eight writes.

Top module: `store_issue_q`

## Requirements
- R1: `in_attr` packs the attributes as bit 3 write-through, bit 2 cache-inhibited, bit 1 coherence-required and bit 0 guarded. On every output beat `out_cacheable` is the inverse of the cache-inhibited bit and `out_wthru` equals the write-through bit.
- R2: `out_snoop` equals the coherence-required bit on every output beat. This holds when the cache-inhibited bit is also set.
- R3: An input with bits 3 and 2 both set is consumed when `in_ready` is high and is never issued. `attr_err` is high for exactly the cycle after each such handshake and is low otherwise.
- R4: Every accepted legal write is issued exactly once, with its address, data and attributes unchanged. This includes writes whose coherence bit is 0. The output is idle only when nothing is held.
- R5: Writes with bits 2 and 0 both set leave in the order they were accepted, for any mix of addresses and coherence bits.
- R6: Whenever a plain write is held, the write offered on the output is a plain write, even if older ordered writes are held.
- R7: The queue holds DEPTH (default 8) writes. `in_ready` is low exactly when DEPTH writes are held.
- R8: A synchronous active-high reset empties the queue and clears `attr_err`. After reset `in_ready` is high and `out_valid` is low.
- R9: Once `out_valid` is high it stays high until an output handshake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming write is present |
| in_ready | output | 1 | Queue can accept a write |
| in_addr | input | AW | Write address |
| in_data | input | DW | Write data |
| in_attr | input | 4 | Attributes {write-through, cache-inhibited, coherence, guarded} |
| out_valid | output | 1 | A write is offered to the bus |
| out_ready | input | 1 | Bus takes the offered write |
| out_addr | output | AW | Address of the offered write |
| out_data | output | DW | Data of the offered write |
| out_attr | output | 4 | Attributes of the offered write |
| out_cacheable | output | 1 | Offered write may be cached |
| out_wthru | output | 1 | Offered write is write-through |
| out_snoop | output | 1 | Offered write must be snooped |
| attr_err | output | 1 | Pulse for a rejected attribute combination |

## Verification
The hardest case to reach from the ports is several ordered writes waiting at once while plain writes keep arriving and overtaking them. Only in that case can the ticket order be upset. The stimulus holds `out_ready` low for long stretches, so the queue fills with a mix weighted toward cache-inhibited guarded writes. It then releases the bus at random. The attribute values are swept through all sixteen codes, so every illegal combination is presented both while the queue is filling and while it is draining.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef struct packed {
        logic wt;   // bit 3
        logic ci;   // bit 2
        logic coh;  // bit 1
        logic grd;  // bit 0
    } mattr_t;

    function automatic logic attr_illegal(mattr_t a);
        return a.wt & a.ci;
    endfunction

    function automatic logic attr_ordered(mattr_t a);
        return a.ci & a.grd;
    endfunction
endpackage

// File: rtl/sq_first_set.sv
module sq_first_set #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/store_issue_q.sv
module store_issue_q
    import sq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [3:0]    in_attr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic [3:0]    out_attr,
    output logic          out_cacheable,
    output logic          out_wthru,
    output logic          out_snoop,
    output logic          attr_err
);
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int TKW = IW + 1;

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        mattr_t         attr;
        logic [TKW-1:0] tkt;
    } entry_t;

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        entry_t [DEPTH-1:0]       ent;
        logic [TKW-1:0]           enq_tkt;
        logic [TKW-1:0]           srv_tkt;
        logic                     err;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] free_req, plain_req, ord_req;
    logic             free_found, plain_found, ord_found;
    logic [IW-1:0]    free_idx, plain_idx, ord_idx, sel_idx;
    mattr_t           in_a;
    entry_t           sel_ent;
    logic             in_hs, out_hs;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign free_req[g]  = ~s_q.vld[g];
        assign plain_req[g] = s_q.vld[g] & ~attr_ordered(s_q.ent[g].attr);
        assign ord_req[g]   = s_q.vld[g] & attr_ordered(s_q.ent[g].attr)
                              & (s_q.ent[g].tkt == s_q.srv_tkt);
    end

    sq_first_set #(.N(DEPTH)) u_free  (.req(free_req),  .found(free_found),  .idx(free_idx));
    sq_first_set #(.N(DEPTH)) u_plain (.req(plain_req), .found(plain_found), .idx(plain_idx));
    sq_first_set #(.N(DEPTH)) u_ord   (.req(ord_req),   .found(ord_found),   .idx(ord_idx));

    always_comb begin
        in_a     = mattr_t'(in_attr);
        sel_idx  = plain_found ? plain_idx : ord_idx;
        sel_ent  = s_q.ent[sel_idx];
        in_ready = free_found;
        out_valid = plain_found | ord_found;
        in_hs    = in_valid & in_ready;
        out_hs   = out_valid & out_ready;

        s_d     = s_q;
        s_d.err = in_hs & attr_illegal(in_a);

        if (out_hs) begin
            s_d.vld[sel_idx] = 1'b0;
            if (attr_ordered(sel_ent.attr)) begin
                s_d.srv_tkt = s_q.srv_tkt + 1'b1;
            end
        end

        if (in_hs && !attr_illegal(in_a)) begin
            s_d.vld[free_idx]      = 1'b1;
            s_d.ent[free_idx].addr = in_addr;
            s_d.ent[free_idx].data = in_data;
            s_d.ent[free_idx].attr = in_a;
            s_d.ent[free_idx].tkt  = s_q.enq_tkt;
            if (attr_ordered(in_a)) begin
                s_d.enq_tkt = s_q.enq_tkt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.vld     <= '0;
            s_q.enq_tkt <= '0;
            s_q.srv_tkt <= '0;
            s_q.err     <= 1'b0;
        end else begin
            s_q.vld     <= s_d.vld;
            s_q.enq_tkt <= s_d.enq_tkt;
            s_q.srv_tkt <= s_d.srv_tkt;
            s_q.err     <= s_d.err;
        end
        s_q.ent <= s_d.ent;
    end

    assign out_addr      = sel_ent.addr;
    assign out_data      = sel_ent.data;
    assign out_attr      = sel_ent.attr;
    assign out_cacheable = ~sel_ent.attr.ci;
    assign out_wthru     = sel_ent.attr.wt;
    assign out_snoop     = sel_ent.attr.coh;
    assign attr_err      = s_q.err;
endmodule

// File: rtl/store_issue_q_chk.sv
module store_issue_q_chk #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [3:0] in_attr,
    input logic       out_valid,
    input logic       out_ready,
    input logic [3:0] out_attr
);
    localparam int OW = $clog2(DEPTH + 1) + 1;

    logic [OW-1:0] occ;
    logic          acc, iss;

    assign acc = in_valid & in_ready & ~(in_attr[3] & in_attr[2]);
    assign iss = out_valid & out_ready;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + OW'(acc) - OW'(iss);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH)); // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (occ == OW'(DEPTH)) |-> !in_ready); // R7
    AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (occ < OW'(DEPTH)) |-> in_ready); // R7
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !out_valid); // R4
    AST_HELD_OFFERED: assert property (@(posedge clk) disable iff (rst)
        (occ != '0) |-> out_valid); // R4
    AST_NO_ILLEGAL_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_attr[3] & out_attr[2])); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid); // R9
endmodule

bind store_issue_q store_issue_q_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_attr(in_attr), .out_valid(out_valid), .out_ready(out_ready),
    .out_attr(out_attr)
);

// File: tb/store_issue_q_test.sv
`timescale 1ns/1ps
module store_issue_q_test;
    localparam int AW = 32, DW = 32, DEPTH = 8, MAXID = 8192;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic [3:0] in_attr = '0;
    logic in_ready, out_valid, out_cacheable, out_wthru, out_snoop, attr_err;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic [3:0] out_attr;

    always #10 clk = ~clk; // 50 MHz

    store_issue_q #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (.*);

    int tests = 0, fails = 0, next_id = 0;
    bit done = 0;
    logic [AW-1:0] exp_addr [MAXID];
    logic [3:0] exp_attr [MAXID];
    bit accepted [MAXID];
    bit issued [MAXID];
    int ordq [MAXID];
    int oh = 0, ot = 0;
    bit prev_ill = 0, prev_stall = 0, last_in_hs = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic observe();
        int id;
        last_in_hs = 0;
        if (rst) begin
            prev_ill = 0; prev_stall = 0;
            return;
        end
        chk(attr_err == prev_ill, "R3", "attr_err pulse", attr_err, prev_ill);
        if (prev_stall) chk(out_valid, "R9", "valid held while stalled", out_valid, 1);
        prev_ill = in_valid && in_ready && in_attr[3] && in_attr[2];
        prev_stall = out_valid && !out_ready;
        if (in_valid && in_ready) begin
            last_in_hs = 1;
            id = int'(in_data);
            if (!(in_attr[3] && in_attr[2])) begin
                accepted[id] = 1; exp_addr[id] = in_addr; exp_attr[id] = in_attr;
                if (in_attr[2] && in_attr[0]) begin ordq[ot] = id; ot++; end
            end
        end
        if (out_valid && out_ready) begin
            id = int'(out_data);
            chk(id < MAXID && accepted[id] && !issued[id], "R4", "issued once", id, id);
            if (id < MAXID) begin
                issued[id] = 1;
                chk(out_addr == exp_addr[id], "R4", "address", out_addr, exp_addr[id]);
                chk(out_attr == exp_attr[id], "R4", "attributes", out_attr, exp_attr[id]);
                chk(out_cacheable == !exp_attr[id][2], "R1", "cacheable", out_cacheable, !exp_attr[id][2]);
                chk(out_wthru == exp_attr[id][3], "R1", "write-through", out_wthru, exp_attr[id][3]);
                chk(out_snoop == exp_attr[id][1], "R2", "snoop", out_snoop, exp_attr[id][1]);
                chk(!(out_attr[3] && out_attr[2]), "R3", "illegal issued", out_attr, 0);
                if (exp_attr[id][2] && exp_attr[id][0]) begin
                    chk(oh < ot && ordq[oh] == id, "R5", "ordered sequence", id, ordq[oh]);
                    oh++;
                end
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        observe();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [3:0] a);
        in_valid = 1; in_attr = a; in_addr = $urandom; in_data = DW'(next_id); next_id++;
        do step(); while (!last_in_hs);
        in_valid = 0;
    endtask

    task automatic drain();
        out_ready = 1;
        for (int i = 0; i < 3 * DEPTH; i++) step();
    endtask

    task automatic do_reset();
        rst = 1;
        for (int i = 0; i < next_id; i++) if (accepted[i] && !issued[i]) accepted[i] = 0;
        oh = ot;
        step(); step();
        rst = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int pending;
        for (int i = 0; i < MAXID; i++) begin accepted[i] = 0; issued[i] = 0; end
        step(); step(); step();
        rst = 0;
        step();
        @(negedge clk);
        chk(in_ready, "R8", "in_ready after reset", in_ready, 1);
        chk(!out_valid, "R8", "out_valid after reset", out_valid, 0);
        chk(!attr_err, "R8", "attr_err after reset", attr_err, 0);
        @(posedge clk); #1;

        // R6: plain write overtakes a waiting ordered one
        out_ready = 0;
        send(4'b0101);
        send(4'b0000);
        @(negedge clk);
        chk(out_valid && out_data == DW'(next_id - 1), "R6", "plain first", out_data, next_id - 1);
        @(posedge clk); #1;
        drain();

        // R7: fill to capacity
        out_ready = 0;
        for (int i = 0; i < DEPTH; i++) send(4'(i % 4));
        @(negedge clk);
        chk(!in_ready, "R7", "in_ready when full", in_ready, 0);
        @(posedge clk); #1;
        drain();

        // R3: illegal codes directed
        send(4'b1100); send(4'b1111); send(4'b1101);
        step(); step();

        // R8: reset with entries held and an error pending
        out_ready = 0;
        send(4'b0010); send(4'b0111); send(4'b1110);
        rst = 1;
        step(); step();
        do_reset();
        @(negedge clk);
        chk(!out_valid, "R8", "queue empty after reset", out_valid, 0);
        chk(in_ready, "R8", "ready after reset", in_ready, 1);
        chk(!attr_err, "R8", "error cleared", attr_err, 0);
        @(posedge clk); #1;

        // Sweep all attribute codes under random backpressure (R1-R5, R9 monitored)
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (!in_valid || last_in_hs) begin
                in_valid = ($urandom % 10) < 7;
                if ($urandom % 3 == 0) in_attr = {1'b0, 1'b1, 1'($urandom), 1'b1};
                else in_attr = 4'(cyc);
                in_addr = $urandom;
                in_data = DW'(next_id);
                next_id++;
            end
            out_ready = ((cyc / 150) % 3 == 1) ? 1'b0 : (($urandom % 4) != 0);
            step();
        end
        in_valid = 0;
        drain();

        pending = 0;
        for (int i = 0; i < next_id; i++) if (accepted[i] && !issued[i]) pending++;
        chk(pending == 0, "R4", "all accepted writes issued", pending, 0);
        chk(oh == ot, "R5", "ordered writes all left", oh, ot);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule